// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sits on the host side of a serial digital-to-analog converter link. It takes a 16-bit signed sample and a 2-bit power-mode code through a valid/ready handshake. It then sends them as one 24-bit frame on three wires: a frame-select strobe, a serial clock and a serial data line. The serial clock comes from the system clock through a divider set by a parameter. The receiver latches data on falling clock edges, so the block changes the data line only while the serial clock is high.

Unlike a conventional SPI master, the frame strobe rests low between frames, which saves power in the receiver. It is pulsed high for a fixed, parameterised number of system cycles just before each frame. That pulse gives the receiver the falling strobe edge that opens a write. The defaults suit a 100 MHz system clock: a 25 MHz serial clock, under the 30 MHz ceiling, and a 40 ns strobe pulse, over the 33 ns minimum.

Top module: `dac_frame_tx`

## Requirements
- R1: While reset is held, and on release, sync_o is 0, sclk_o is 1, din_o is 0 and in_ready is 1.
- R2: Each frame carries 24 bits, most significant first: six zeros, then in_mode[1] and in_mode[0], then in_sample[15:0] unchanged. A sample of 0 is sent as sixteen zero bits, the two's complement midscale code.
- R3: After a handshake, sync_o is high for exactly SYNC_HI_CYC system cycles and then falls. The first falling edge of sclk_o follows SCLK_HALF_CYC cycles after sync_o falls.
- R4: Within a frame, sclk_o has exactly 24 falling edges, spaced 2*SCLK_HALF_CYC system cycles apart. sync_o stays low throughout, and sclk_o never toggles while sync_o is high.
- R5: din_o changes only when sclk_o is high after that cycle. It holds the same value in the cycle before every falling edge of sclk_o and in the cycle of that edge.
- R6: Between frames, sync_o rests low, sclk_o rests high and din_o is 0.
- R7: in_ready drops in the cycle after a handshake. It returns exactly 3*SCLK_HALF_CYC system cycles after the 24th falling edge of sclk_o.
- R8: in_valid and the data inputs are ignored while in_ready is low. If in_valid is held high, a new frame is accepted in the first cycle that in_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample and mode are presented |
| in_ready | output | 1 | Block can accept a new frame |
| in_sample | input | 16 | Two's complement sample |
| in_mode | input | 2 | Power-mode code: 00 active, others power-down options |
| sync_o | output | 1 | Frame strobe: high pulse before a frame, low during and between frames |
| sclk_o | output | 1 | Serial clock, rests high |
| din_o | output | 1 | Serial data, stable around falling sclk_o edges |

## Verification
The end of the idle period after a frame can coincide with a new handshake. In that cycle in_ready rises, and a request waiting on in_valid is taken at once, raising sync_o. The bench holds in_valid high across frames so that each new frame is accepted right at the return of in_ready. It checks that in_ready returns exactly 3*SCLK_HALF_CYC cycles after the 24th falling edge, and that the strobe pulse that follows has the full width. It also changes the data inputs while the block is busy and checks that only the accepted words appear, in order, on the serial line.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
  localparam int PAD_BITS    = 6;
  localparam int MODE_BITS   = 2;
  localparam int SAMPLE_BITS = 16;
  localparam int FRAME_BITS  = PAD_BITS + MODE_BITS + SAMPLE_BITS;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_SHIFT,
    ST_TAIL
  } seq_state_t;

  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic [MODE_BITS-1:0]   mode,
    input logic [SAMPLE_BITS-1:0] sample
  );
    return {{PAD_BITS{1'b0}}, mode, sample};
  endfunction
endpackage

// File: rtl/dac_cycle_timer.sv
module dac_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             take,
  output logic             head_bit
);
  logic [WIDTH-1:0] sreg;

  assign head_bit = sreg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (load) sreg <= load_val;
    else if (take) sreg <= {sreg[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int SCLK_HALF_CYC = 2,
  parameter int SYNC_HI_CYC   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SAMPLE_BITS-1:0] in_sample,
  input  logic [MODE_BITS-1:0]   in_mode,
  output logic                   sync_o,
  output logic                   sclk_o,
  output logic                   din_o
);
  localparam int TAIL_CYC = 2 * SCLK_HALF_CYC;
  localparam int MAX_CYC  = (TAIL_CYC > SYNC_HI_CYC) ? TAIL_CYC : SYNC_HI_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int FALL_W   = $clog2(FRAME_BITS + 1);

  seq_state_t        state;
  logic [FALL_W-1:0] fall_cnt;
  logic [CNT_W-1:0]  limit;
  logic              expire, accept, take, head_bit, last_fall_done;

  assign accept         = in_valid && in_ready;
  assign last_fall_done = (fall_cnt == FALL_W'(FRAME_BITS));
  assign take = expire && ((state == ST_STROBE) ||
                           (state == ST_SHIFT && !sclk_o && !last_fall_done));

  always_comb begin
    case (state)
      ST_STROBE: limit = CNT_W'(SYNC_HI_CYC);
      ST_TAIL:   limit = CNT_W'(TAIL_CYC);
      default:   limit = CNT_W'(SCLK_HALF_CYC);
    endcase
  end

  dac_cycle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .run    (state != ST_IDLE),
    .limit  (limit),
    .expire (expire)
  );

  dac_frame_shift #(.WIDTH(FRAME_BITS)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (pack_frame(in_mode, in_sample)),
    .take     (take),
    .head_bit (head_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fall_cnt <= '0;
      in_ready <= 1'b1;
      sync_o   <= 1'b0;
      sclk_o   <= 1'b1;
      din_o    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_STROBE;
          in_ready <= 1'b0;
          sync_o   <= 1'b1;
          fall_cnt <= '0;
        end
        ST_STROBE: if (expire) begin
          state  <= ST_SHIFT;
          sync_o <= 1'b0;
          din_o  <= head_bit;
        end
        ST_SHIFT: if (expire) begin
          if (sclk_o) begin
            sclk_o   <= 1'b0;
            fall_cnt <= fall_cnt + 1'b1;
          end else begin
            sclk_o <= 1'b1;
            if (last_fall_done) begin
              state <= ST_TAIL;
              din_o <= 1'b0;
            end else begin
              din_o <= head_bit;
            end
          end
        end
        ST_TAIL: if (expire) begin
          state    <= ST_IDLE;
          in_ready <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sync_o,
  input logic sclk_o,
  input logic din_o
);
  // R6
  rest_levels_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!sync_o && sclk_o && !din_o));

  // R4
  no_fall_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> !sync_o);

  // R5
  din_settled_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> $stable(din_o));

  // R5
  din_moves_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(din_o) |-> sclk_o);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && sync_o));

  // R3
  strobe_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(in_valid && in_ready));
endmodule

bind dac_frame_tx dac_frame_tx_chk chk_i (.*);

// File: tb/dac_frame_tx_test.sv
module dac_frame_tx_test;
  localparam int H = 2;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [1:0]  in_mode = '0;
  logic        in_ready, sync_o, sclk_o, din_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int n_acc    = 0;
  int n_done   = 0;
  bit finished = 1'b0;
  logic [23:0] exp_q[$];

  always #5 clk = ~clk;

  dac_frame_tx #(.SCLK_HALF_CYC(H), .SYNC_HI_CYC(S)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_mode(in_mode),
    .sync_o(sync_o), .sclk_o(sclk_o), .din_o(din_o)
  );

  function automatic logic [23:0] ref_frame(logic [1:0] m, logic [15:0] s);
    return {6'b000000, m, s};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // monitor sampled away from the active edge
  logic psync = 1'b0, psclk = 1'b1, pdin = 1'b0, pready = 1'b1, acc_prev = 1'b0;
  int t_rise = 0, t_sfall = 0, t_lfall = 0, falls = 0;
  logic [23:0] cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (acc_prev) begin
        check(!in_ready && sync_o, "R7", {in_ready, sync_o}, 2'b01);
      end
      if (!psync && sync_o) t_rise = cyc;
      if (psync && !sync_o) begin
        check(cyc - t_rise == S, "R3 strobe width", cyc - t_rise, S);
        t_sfall = cyc;
        falls = 0;
      end
      if (din_o != pdin) check(sclk_o, "R5 din moved with sclk low", sclk_o, 1);
      if (psclk && !sclk_o) begin
        check(!sync_o, "R4 sync low at fall", sync_o, 0);
        check(din_o == pdin, "R5 din stable at fall", din_o, pdin);
        if (falls == 0) check(cyc - t_sfall == H, "R3 first fall", cyc - t_sfall, H);
        else            check(cyc - t_lfall == 2*H, "R4 fall spacing", cyc - t_lfall, 2*H);
        cap = {cap[22:0], din_o};
        falls++;
        t_lfall = cyc;
        if (falls == 24) begin
          logic [23:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 24'hxxxxxx;
          check(cap === e, "R2 frame content", cap, e);
          n_done++;
        end
      end
      if (!pready && in_ready) begin
        check(cyc - t_lfall == 3*H, "R7 ready return", cyc - t_lfall, 3*H);
        check(falls == 24, "R4 fall count", falls, 24);
        check(!sync_o && sclk_o && !din_o, "R6 rest levels",
              {sync_o, sclk_o, din_o}, 3'b010);
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        exp_q.push_back(ref_frame(in_mode, in_sample));
        n_acc++;
      end
    end
    psync = sync_o; psclk = sclk_o; pdin = din_o; pready = in_ready;
  end

  task automatic send(logic [1:0] m, logic [15:0] s, bit keep);
    @(posedge clk); #1;
    in_valid = 1'b1; in_mode = m; in_sample = s;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(in_ready && exp_q.size() == 0));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({sync_o, sclk_o, din_o, in_ready} == 4'b0101, "R1 reset state",
          {sync_o, sclk_o, din_o, in_ready}, 4'b0101);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check({sync_o, sclk_o, din_o, in_ready} == 4'b0101, "R1 after release",
          {sync_o, sclk_o, din_o, in_ready}, 4'b0101);

    // R2 directed codes: midscale, extremes, all ones
    send(2'b00, 16'h0000, 0); wait_idle();
    send(2'b11, 16'h8000, 0); wait_idle();
    send(2'b01, 16'h7FFF, 0); wait_idle();
    send(2'b10, 16'hFFFF, 0); wait_idle();

    // R8 back-to-back with in_valid held across frames
    send(2'b00, 16'h1234, 1);
    send(2'b01, 16'hA5C3, 1);
    send(2'b10, 16'h0F0F, 0);
    wait_idle();

    // R8 changing inputs while busy must be ignored
    send(2'b00, 16'h5555, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 30; i++) begin
      in_valid = 1'b1; in_sample = 16'($urandom); in_mode = 2'($urandom);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    wait_idle();

    // random traffic
    for (int i = 0; i < 40; i++) begin
      send(2'($urandom), 16'($urandom), bit'($urandom % 2));
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        repeat ($urandom % 7) @(posedge clk);
      end
    end
    in_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(n_done == n_acc, "R8 frames sent equal accepted", n_done, n_acc);
    check(!sync_o && sclk_o, "R6 final rest", {sync_o, sclk_o}, 2'b01);
    finish_run();
  end
endmodule